// File: doc/BRIEF.md
# Nine-Stage Halving Decimator for Complex Samples

This block lowers the sample rate of a complex (I/Q) stream by a factor of 512. It does this with nine stages in a row, and each stage halves the rate. Every stage lowpass filters its own input, then keeps only every second filtered value. A fast digitized baseband at 32768 kHz therefore comes out at 64 kHz, which is wide enough to carry a 48 kHz signal group.

The seven front stages run at the highest rates, so they use the multiplier-free kernel 1-2-1. It is built from one shift and two adds, and a right shift of two restores unity gain. The two back stages run at very low rates. They apply a longer symmetric 7-tap lowpass kernel. Its coefficients sit in a small table, and one multiplier per rail is shared across the taps over several cycles.

Samples enter with a valid strobe, which may have gaps. Results leave with a one-cycle valid strobe. All data words are 16-bit two's complement, and the I and Q rails are processed identically.

Top module: `decim_cascade`

## Requirements
- R1: A synchronous reset clears every delay line and every stage's decimation phase. In the cycle after reset is sampled, out_valid is 0 and out_i and out_q are 0.
- R2: Each stage emits one result on the 2nd, 4th, 6th and later valid inputs it receives after reset. The whole block therefore emits exactly one result for each 512 valid inputs. out_valid is a single-cycle pulse, and two pulses are never fewer than 511 cycles apart.
- R3: Each of the first seven stages produces floor((x[n] + 2*x[n-1] + x[n-2]) / 4). Here x[n] is the input that triggers the result, and x[n-1] and x[n-2] are the two valid inputs before it, which are 0 after reset.
- R4: Each of the last two stages produces floor(S / 32), where S = -x[n] + 9*x[n-2] + 16*x[n-3] + 9*x[n-4] - x[n-6]. That result saturates to the range -32768..32767.
- R5: A constant input on both rails gives that same constant at the output once the delay lines have filled (unity DC gain, exact).
- R6: Idle cycles between valid inputs have no effect on the output values.
- R7: out_i and out_q hold their values between out_valid pulses.
- R8: The I and Q rails are independent. A rail held at 0 stays at 0 whatever the other rail carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase input sample, two's complement |
| in_q | input | 16 | Quadrature input sample, two's complement |
| out_valid | output | 1 | Output sample strobe, one cycle wide |
| out_i | output | 16 | In-phase output sample |
| out_q | output | 16 | Quadrature output sample |

## Verification
The bench runs a bit-exact scoreboard for the whole chain. Any error in the 1-2-1 rounding, in the tap alignment of the 7-tap kernel or in a stage's halving phase therefore shows up as a value mismatch or as a strobe that should not be there.

A full-scale step makes the negative end taps overshoot. A design without saturation would wrap to the opposite sign at that point.

Random gaps in the input strobe catch a stage that advances its delay line or phase on idle cycles. A reset in the middle of a frame catches leftover history or a phase that is not cleared, since either one would corrupt the first result after reset.

// File: rtl/decim_pkg.sv
package decim_pkg;
    localparam int FIR_TAPS  = 7;
    localparam int FIR_HALF  = (FIR_TAPS - 1) / 2;
    localparam int COEF_W    = 6;
    localparam int FIR_SHIFT = 5;

    // Half of the symmetric back-stage kernel; index FIR_HALF is the centre tap.
    function automatic logic signed [COEF_W-1:0] fir_coef(input int idx);
        case (idx)
            0:       return -6'sd1;
            1:       return  6'sd0;
            2:       return  6'sd9;
            default: return  6'sd16;
        endcase
    endfunction
endpackage

// File: rtl/decim_hb_stage.sv
module decim_hb_stage #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_v,
    input  logic signed [W-1:0] in_i,
    input  logic signed [W-1:0] in_q,
    output logic                out_v,
    output logic signed [W-1:0] out_i,
    output logic signed [W-1:0] out_q
);
    typedef struct packed {
        logic                phase;
        logic signed [W-1:0] i1;
        logic signed [W-1:0] i2;
        logic signed [W-1:0] q1;
        logic signed [W-1:0] q2;
        logic signed [W-1:0] oi;
        logic signed [W-1:0] oq;
        logic                ov;
    } hb_state_t;

    hb_state_t st_d, st_q;

    function automatic logic signed [W-1:0] smooth(input logic signed [W-1:0] a,
                                                   input logic signed [W-1:0] b,
                                                   input logic signed [W-1:0] c);
        logic signed [W+1:0] s;
        s = (W+2)'(a) + ((W+2)'(b) <<< 1) + (W+2)'(c);
        return s[W+1:2];
    endfunction

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        if (in_v) begin
            st_d.i2    = st_q.i1;
            st_d.i1    = in_i;
            st_d.q2    = st_q.q1;
            st_d.q1    = in_q;
            st_d.phase = ~st_q.phase;
            if (st_q.phase) begin
                st_d.oi = smooth(in_i, st_q.i1, st_q.i2);
                st_d.oq = smooth(in_q, st_q.q1, st_q.q2);
                st_d.ov = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_v = st_q.ov;
    assign out_i = st_q.oi;
    assign out_q = st_q.oq;
endmodule

// File: rtl/decim_fir_stage.sv
module decim_fir_stage
    import decim_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_v,
    input  logic signed [W-1:0] in_i,
    input  logic signed [W-1:0] in_q,
    output logic                out_v,
    output logic signed [W-1:0] out_i,
    output logic signed [W-1:0] out_q
);
    localparam int K_W   = $clog2(FIR_HALF + 1);
    localparam int ACC_W = W + 1 + COEF_W + K_W;
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - 1;

    typedef struct packed {
        logic                            phase;
        logic                            busy;
        logic [K_W-1:0]                  k;
        logic [FIR_TAPS-1:0][W-1:0]      hi;
        logic [FIR_TAPS-1:0][W-1:0]      hq;
        logic signed [ACC_W-1:0]         acci;
        logic signed [ACC_W-1:0]         accq;
        logic signed [W-1:0]             oi;
        logic signed [W-1:0]             oq;
        logic                            ov;
    } fir_state_t;

    fir_state_t st_d, st_q;

    function automatic logic signed [W-1:0] clamp(input logic signed [ACC_W-1:0] acc);
        logic signed [ACC_W-1:0] sh;
        sh = acc >>> FIR_SHIFT;
        if (sh > MAXV)      sh = MAXV;
        else if (sh < MINV) sh = MINV;
        return sh[W-1:0];
    endfunction

    logic signed [W:0]       pair_i, pair_q;
    logic signed [COEF_W-1:0] cf;
    logic signed [ACC_W-1:0] nxt_i, nxt_q;

    always_comb begin
        int kk;
        kk = int'(st_q.k);
        cf = fir_coef(kk);
        if (kk == FIR_HALF) begin
            pair_i = (W+1)'($signed(st_q.hi[kk]));
            pair_q = (W+1)'($signed(st_q.hq[kk]));
        end else begin
            pair_i = (W+1)'($signed(st_q.hi[kk])) + (W+1)'($signed(st_q.hi[FIR_TAPS-1-kk]));
            pair_q = (W+1)'($signed(st_q.hq[kk])) + (W+1)'($signed(st_q.hq[FIR_TAPS-1-kk]));
        end
        nxt_i = st_q.acci + cf * pair_i;
        nxt_q = st_q.accq + cf * pair_q;
    end

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        if (st_q.busy) begin
            st_d.acci = nxt_i;
            st_d.accq = nxt_q;
            if (int'(st_q.k) == FIR_HALF) begin
                st_d.oi   = clamp(nxt_i);
                st_d.oq   = clamp(nxt_q);
                st_d.ov   = 1'b1;
                st_d.busy = 1'b0;
            end else begin
                st_d.k = st_q.k + 1'b1;
            end
        end
        if (in_v) begin
            st_d.hi    = {st_q.hi[FIR_TAPS-2:0], in_i};
            st_d.hq    = {st_q.hq[FIR_TAPS-2:0], in_q};
            st_d.phase = ~st_q.phase;
            if (st_q.phase) begin
                st_d.busy = 1'b1;
                st_d.k    = '0;
                st_d.acci = '0;
                st_d.accq = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_v = st_q.ov;
    assign out_i = st_q.oi;
    assign out_q = st_q.oq;
endmodule

// File: rtl/decim_cascade.sv
module decim_cascade #(
    parameter int W                = 16,
    parameter int NUM_STAGES       = 9,
    parameter int NUM_SHIFT_STAGES = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_i,
    input  logic signed [W-1:0] in_q,
    output logic                out_valid,
    output logic signed [W-1:0] out_i,
    output logic signed [W-1:0] out_q
);
    logic                sv [NUM_STAGES+1];
    logic signed [W-1:0] si [NUM_STAGES+1];
    logic signed [W-1:0] sq [NUM_STAGES+1];

    assign sv[0] = in_valid;
    assign si[0] = in_i;
    assign sq[0] = in_q;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        if (g < NUM_SHIFT_STAGES) begin : g_shift
            decim_hb_stage #(.W(W)) u_stage (
                .clk(clk), .rst(rst),
                .in_v(sv[g]), .in_i(si[g]), .in_q(sq[g]),
                .out_v(sv[g+1]), .out_i(si[g+1]), .out_q(sq[g+1])
            );
        end else begin : g_mac
            decim_fir_stage #(.W(W)) u_stage (
                .clk(clk), .rst(rst),
                .in_v(sv[g]), .in_i(si[g]), .in_q(sq[g]),
                .out_v(sv[g+1]), .out_i(si[g+1]), .out_q(sq[g+1])
            );
        end
    end

    assign out_valid = sv[NUM_STAGES];
    assign out_i     = si[NUM_STAGES];
    assign out_q     = sq[NUM_STAGES];
endmodule

// File: rtl/decim_cascade_chk.sv
module decim_cascade_chk #(
    parameter int W     = 16,
    parameter int RATIO = 512
) (
    input logic         clk,
    input logic         rst,
    input logic         out_valid,
    input logic [W-1:0] out_i,
    input logic [W-1:0] out_q
);
    localparam int GW = $clog2(RATIO + 1) + 1;
    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst || out_valid)   gap <= '0;
        else if (gap != GW'(RATIO)) gap <= gap + 1'b1;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_i == '0 && out_q == '0));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r2_min_spacing: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (gap >= GW'(RATIO - 1)));

    a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind decim_cascade decim_cascade_chk #(.W(W), .RATIO(1 << NUM_STAGES)) u_chk (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/tb_decim_cascade.sv
module tb_decim_cascade;
    localparam int W  = 16;
    localparam int NS = 9;
    localparam int NH = 7;
    localparam int TAPS = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [W-1:0] in_i = '0, in_q = '0;
    logic out_valid;
    logic signed [W-1:0] out_i, out_q;

    decim_cascade dut (.*);

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;
    string tag = "R2";

    typedef struct { int i; int q; } pair_t;
    pair_t exp_q[$];

    // reference state
    int m_ph [NS];
    int m_i1 [NS], m_i2 [NS], m_q1 [NS], m_q2 [NS];
    int f_hi [NS][TAPS], f_hq [NS][TAPS];
    int last_i = 0, last_q = 0;

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_ph[s] = 0; m_i1[s] = 0; m_i2[s] = 0; m_q1[s] = 0; m_q2[s] = 0;
            for (int t = 0; t < TAPS; t++) begin f_hi[s][t] = 0; f_hq[s][t] = 0; end
        end
    endtask

    function automatic int sat16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int kern7(int h[TAPS]);
        int s;
        s = -h[0] + 9*h[2] + 16*h[3] + 9*h[4] - h[6];
        return sat16(s >>> 5);
    endfunction

    task automatic model_step(input int vi, input int vq);
        int ci, cq, yi, yq;
        bit go;
        int hi[TAPS], hq[TAPS];
        ci = vi; cq = vq; go = 1;
        for (int s = 0; s < NS && go; s++) begin
            if (s < NH) begin
                yi = (ci + 2*m_i1[s] + m_i2[s]) >>> 2;
                yq = (cq + 2*m_q1[s] + m_q2[s]) >>> 2;
                m_i2[s] = m_i1[s]; m_i1[s] = ci;
                m_q2[s] = m_q1[s]; m_q1[s] = cq;
            end else begin
                for (int t = TAPS-1; t > 0; t--) begin
                    f_hi[s][t] = f_hi[s][t-1]; f_hq[s][t] = f_hq[s][t-1];
                end
                f_hi[s][0] = ci; f_hq[s][0] = cq;
                for (int t = 0; t < TAPS; t++) begin hi[t] = f_hi[s][t]; hq[t] = f_hq[s][t]; end
                yi = kern7(hi); yq = kern7(hq);
            end
            if (m_ph[s] == 0) begin
                m_ph[s] = 1; go = 0;
            end else begin
                m_ph[s] = 0; ci = yi; cq = yq;
            end
        end
        if (go) exp_q.push_back('{ci, cq});
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected output strobe", 1, 0);
                end else begin
                    pair_t e;
                    e = exp_q.pop_front();
                    check(int'(out_i) == e.i, tag, "out_i", int'(out_i), e.i);
                    check(int'(out_q) == e.q, tag, "out_q", int'(out_q), e.q);
                end
                last_i = int'(out_i); last_q = int'(out_q);
            end else begin
                check(int'(out_i) == last_i && int'(out_q) == last_q, "R7", "held output", int'(out_i), last_i);
            end
        end
    end

    task automatic drive(input int vi, input int vq);
        @(negedge clk);
        in_valid = 1'b1; in_i = W'(vi); in_q = W'(vq);
        model_step(vi, vq);
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); in_valid = 1'b0; end
    endtask

    task automatic do_reset();
        @(negedge clk); in_valid = 1'b0; rst = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(out_i == '0 && out_q == '0, "R1", "out_i in reset", int'(out_i), 0);
        model_reset();
        exp_q.delete();
        last_i = 0; last_q = 0;
        rst = 1'b0;
    endtask

    task automatic drain(input string req);
        idle(60);
        check(exp_q.size() == 0, req, "missing outputs", exp_q.size(), 0);
    endtask

    initial begin
        model_reset();
        do_reset();

        // R5: DC on both rails, unity gain once filled
        tag = "R5";
        for (int n = 0; n < 16*512; n++) drive(-1234, 777);
        drain("R2");
        check(last_i == -1234, "R5", "DC I", last_i, -1234);
        check(last_q == 777,   "R5", "DC Q", last_q, 777);

        // R3/R4/R6/R8: random I, Q held at zero, random gaps
        do_reset();
        tag = "R6";
        for (int n = 0; n < 20*512; n++) begin
            drive(int'($urandom_range(0, 65535)) - 32768, 0);
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
        end
        drain("R6");
        check(last_q == 0, "R8", "Q stays zero", last_q, 0);

        // R3/R4: random on both rails, back-to-back
        tag = "R3";
        for (int n = 0; n < 12*512; n++)
            drive(int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768);
        drain("R3");

        // R4: full-scale step forces overshoot saturation
        do_reset();
        tag = "R4";
        for (int n = 0; n < 10*512; n++) drive(32767, -32768);
        for (int n = 0; n < 10*512; n++) drive(-32768, 32767);
        drain("R4");
        check(last_i == -32768, "R4", "settled low I", last_i, -32768);

        // R1: reset mid-frame, then fresh history and phase
        tag = "R1";
        for (int n = 0; n < 700; n++) drive(20000, -20000);
        do_reset();
        tag = "R1";
        for (int n = 0; n < 4*512; n++) drive(1000, -1000);
        drain("R1");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule